// File: doc/BRIEF.md
# USB IN Endpoint Arming Controller

This block tracks who owns the transmit buffer of each of seven USB IN endpoints, numbered 1 to 7, and decides how each endpoint answers an IN token from the host. The CPU fills an endpoint's buffer while that endpoint is idle. It then writes the number of bytes to send into the endpoint's byte count register, and that write arms the endpoint. Once armed, the endpoint answers the next IN token with DATA, and it stays armed until the USB side reports that the transfer has completed. While the CPU still owns the buffer, tokens are answered with NAK. A per-endpoint stall flag forces a STALL answer.

Software cannot arm an endpoint directly through its status register. It can only disarm it, by writing a 1 to the busy bit, for example after a bus reset or a change of alternate setting. For an endpoint pair, both endpoints must be disarmed, one write each. Every time an endpoint goes from armed to idle, the block raises an interrupt request for that endpoint. The request is latched in a pending register until software acknowledges it.

The buffer RAM, packet serialization and CRC live outside this block. The handshake output, together with the byte count it carries, tells the packet engine what to send.

Top module: `usb_in_arm_ctrl`

## Requirements
- R1: After reset every endpoint is idle (busy 0), unstalled, has byte count 0, and no interrupt is pending.
- R2: A CPU write to the byte count register of an idle endpoint sets its busy bit to 1 and stores the written value (low 7 bits). The byte count register sits at address region 1, and the address bits [2:0] hold the endpoint number.
- R3: When xfer_done is asserted with xfer_ep naming a busy endpoint, that endpoint's busy bit clears on the next clock edge. When xfer_done names an idle endpoint or endpoint 0, nothing changes.
- R4: An IN token (tok_valid with tok_ep in 1..7) to an endpoint with busy 0 and stall 0 is answered one cycle later with hs_valid=1 and hs_code=2'b10 (NAK). A token to endpoint 0 produces no handshake (hs_valid=0, hs_code=2'b00).
- R5: A token to an endpoint with busy 1 and stall 0 is answered one cycle later with hs_code=2'b01 (DATA), and hs_len carries the stored byte count. Every other answer has hs_len=0.
- R6: A token to an endpoint whose stall bit is 1 is answered with hs_code=2'b11 (STALL), whatever the state of its busy bit.
- R7: A CPU write to an endpoint's status register (region 0) clears the busy bit when data bit 1 is 1, leaves it unchanged when data bit 1 is 0, and never sets it. The same write copies data bit 0 into the stall bit.
- R8: Reading the status register returns busy in bit 1, stall in bit 0 and zeros in bits 7:2. Reading the byte count returns the stored value zero-extended. Reading the pending register (region 2, endpoint field 0) returns endpoint n's pending bit in bit n and 0 in bit 0. Any other address reads 0. Address bits [4:3] select the region.
- R9: Every 1-to-0 transition of an endpoint's busy bit, whether it comes from a transfer completing or from a disarm, sets that endpoint's bit in irq_pend. irq_any is high whenever any bit of irq_pend is set.
- R10: Writing to the pending register clears each pending bit n for which data bit n is 1. If a new request for an endpoint arrives in the same cycle as a clear of that endpoint's bit, the bit stays set.
- R11: A byte count write to an endpoint that is already busy is ignored. The busy bit stays 1 and the stored byte count is unchanged.
- R12: A disarm write affects only the endpoint it addresses. To disarm a pair, the CPU writes once to each endpoint of the pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_waddr | input | 5 | Write address: [4:3] region, [2:0] endpoint |
| cpu_wdata | input | 8 | Write data |
| cpu_raddr | input | 5 | Read address, same layout as the write address |
| cpu_rdata | output | 8 | Combinational read data |
| tok_valid | input | 1 | IN token received this cycle |
| tok_ep | input | 3 | Endpoint number of the token |
| hs_valid | output | 1 | Handshake decision valid, one cycle after the token |
| hs_code | output | 2 | 01 DATA, 10 NAK, 11 STALL, 00 none |
| hs_len | output | 7 | Byte count to send with a DATA answer |
| xfer_done | input | 1 | IN transfer to the host completed |
| xfer_ep | input | 3 | Endpoint whose transfer completed |
| irq_pend | output | 7 | Pending interrupt request per endpoint (bit 0 is endpoint 1) |
| irq_any | output | 1 | OR of all pending requests |

## Verification
Directed sequences first walk a single endpoint through idle, armed, stalled and completed. This separates NAK from DATA from STALL, and shows that a repeated byte count write leaves the first count in place. Further directed cycles make two events land on the same edge: a completion together with a pending clear, a disarm of one half of a pair while the other half stays armed, and a completion for an idle endpoint. These tell a correct priority apart from one where the later event wins. Random cycles then mix writes, tokens and completions across all regions and endpoints, including endpoint 0 and the unused region. A reference model checks every handshake, the pending vector and a random readback in every cycle.

// File: rtl/usb_in_arm_pkg.sv
package usb_in_arm_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_DATA  = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_code_e;

  typedef enum logic [1:0] {
    RG_STAT = 2'd0,
    RG_BCNT = 2'd1,
    RG_PEND = 2'd2,
    RG_RSVD = 2'd3
  } reg_sel_e;

  // Answer for a token given the endpoint state: stall first, then armed data, else NAK.
  function automatic hs_code_e hs_pick(input logic busy, input logic stall);
    if (stall)     return HS_STALL;
    else if (busy) return HS_DATA;
    else           return HS_NAK;
  endfunction

  // Status register image: busy at bit 1, stall at bit 0, upper bits zero.
  function automatic logic [7:0] fmt_status(input logic busy, input logic stall);
    return {6'b0, busy, stall};
  endfunction

  // Next busy value for one endpoint.
  function automatic logic busy_next(input logic busy, input logic arm,
                                     input logic disarm, input logic done);
    if (!busy) return arm;
    else       return !(disarm || done);
  endfunction

endpackage

// File: rtl/usb_in_ep_state.sv
module usb_in_ep_state
  import usb_in_arm_pkg::*;
#(
  parameter int BCNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_wr,
  input  logic [BCNT_W-1:0] bcnt_in,
  input  logic              disarm,
  input  logic              stall_wr,
  input  logic              stall_in,
  input  logic              done,
  output logic              busy,
  output logic              stall,
  output logic [BCNT_W-1:0] bcnt,
  output logic              arm_evt,
  output logic              fall_evt
);

  logic busy_d;

  assign arm_evt  = arm_wr && !busy;
  assign busy_d   = busy_next(busy, arm_wr, disarm, done);
  assign fall_evt = busy && !busy_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      stall <= 1'b0;
      bcnt  <= '0;
    end else begin
      busy <= busy_d;
      if (stall_wr) stall <= stall_in;
      if (arm_evt)  bcnt  <= bcnt_in;
    end
  end

endmodule

// File: rtl/usb_in_hs_resp.sv
module usb_in_hs_resp
  import usb_in_arm_pkg::*;
#(
  parameter int NUM_EP = 7,
  parameter int EP_W   = 3,
  parameter int BCNT_W = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tok_valid,
  input  logic [EP_W-1:0]                tok_ep,
  input  logic [NUM_EP:1]                busy_vec,
  input  logic [NUM_EP:1]                stall_vec,
  input  logic [NUM_EP:1][BCNT_W-1:0]    bcnt_arr,
  output logic                           hs_valid,
  output hs_code_e                       hs_code,
  output logic [BCNT_W-1:0]              hs_len
);

  logic              ep_ok;
  logic              sel_busy;
  logic              sel_stall;
  logic [BCNT_W-1:0] sel_len;
  hs_code_e          code_d;

  always_comb begin
    ep_ok     = 1'b0;
    sel_busy  = 1'b0;
    sel_stall = 1'b0;
    sel_len   = '0;
    for (int e = 1; e <= NUM_EP; e++) begin
      if (tok_ep == EP_W'(e)) begin
        ep_ok     = 1'b1;
        sel_busy  = busy_vec[e];
        sel_stall = stall_vec[e];
        sel_len   = bcnt_arr[e];
      end
    end
    code_d = (tok_valid && ep_ok) ? hs_pick(sel_busy, sel_stall) : HS_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
      hs_len   <= '0;
    end else begin
      hs_valid <= tok_valid && ep_ok;
      hs_code  <= code_d;
      hs_len   <= (code_d == HS_DATA) ? sel_len : '0;
    end
  end

endmodule

// File: rtl/usb_in_irq_latch.sv
module usb_in_irq_latch #(
  parameter int NUM_EP = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NUM_EP:1] fall_vec,
  input  logic [NUM_EP:1] clr_vec,
  output logic [NUM_EP:1] pend
);

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | fall_vec;
  end

endmodule

// File: rtl/usb_in_arm_ctrl.sv
module usb_in_arm_ctrl
  import usb_in_arm_pkg::*;
#(
  parameter int NUM_EP = 7,
  parameter int BCNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [4:0]        cpu_waddr,
  input  logic [7:0]        cpu_wdata,
  input  logic [4:0]        cpu_raddr,
  output logic [7:0]        cpu_rdata,
  input  logic              tok_valid,
  input  logic [2:0]        tok_ep,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic [BCNT_W-1:0] hs_len,
  input  logic              xfer_done,
  input  logic [2:0]        xfer_ep,
  output logic [NUM_EP:1]   irq_pend,
  output logic              irq_any
);

  localparam int EP_W   = $clog2(NUM_EP + 1);
  localparam int ADDR_W = EP_W + 2;
  localparam int DATA_W = 8;

  reg_sel_e                   wsel;
  reg_sel_e                   rsel;
  logic [EP_W-1:0]            wep;
  logic [EP_W-1:0]            rep;
  logic [NUM_EP:1]            arm_wr;
  logic [NUM_EP:1]            stat_wr;
  logic [NUM_EP:1]            disarm;
  logic [NUM_EP:1]            done_vec;
  logic [NUM_EP:1]            busy_vec;
  logic [NUM_EP:1]            stall_vec;
  logic [NUM_EP:1]            arm_evt;
  logic [NUM_EP:1]            fall_vec;
  logic [NUM_EP:1]            clr_vec;
  logic [NUM_EP:1]            pend;
  logic [NUM_EP:1][BCNT_W-1:0] bcnt_arr;
  hs_code_e                   hs_code_i;

  assign wsel = reg_sel_e'(cpu_waddr[ADDR_W-1:EP_W]);
  assign wep  = cpu_waddr[EP_W-1:0];
  assign rsel = reg_sel_e'(cpu_raddr[ADDR_W-1:EP_W]);
  assign rep  = cpu_raddr[EP_W-1:0];

  // Acknowledge mask for the pending register.
  assign clr_vec = (cpu_we && wsel == RG_PEND && wep == '0) ? cpu_wdata[NUM_EP:1] : '0;

  for (genvar e = 1; e <= NUM_EP; e++) begin : g_ep
    logic hit;
    assign hit         = cpu_we && (wep == EP_W'(e));
    assign arm_wr[e]   = hit && (wsel == RG_BCNT);
    assign stat_wr[e]  = hit && (wsel == RG_STAT);
    assign disarm[e]   = stat_wr[e] && cpu_wdata[1];
    assign done_vec[e] = xfer_done && (xfer_ep == EP_W'(e));

    usb_in_ep_state #(.BCNT_W(BCNT_W)) u_ep (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_wr   (arm_wr[e]),
      .bcnt_in  (cpu_wdata[BCNT_W-1:0]),
      .disarm   (disarm[e]),
      .stall_wr (stat_wr[e]),
      .stall_in (cpu_wdata[0]),
      .done     (done_vec[e]),
      .busy     (busy_vec[e]),
      .stall    (stall_vec[e]),
      .bcnt     (bcnt_arr[e]),
      .arm_evt  (arm_evt[e]),
      .fall_evt (fall_vec[e])
    );
  end

  usb_in_hs_resp #(.NUM_EP(NUM_EP), .EP_W(EP_W), .BCNT_W(BCNT_W)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_ep    (tok_ep),
    .busy_vec  (busy_vec),
    .stall_vec (stall_vec),
    .bcnt_arr  (bcnt_arr),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code_i),
    .hs_len    (hs_len)
  );

  usb_in_irq_latch #(.NUM_EP(NUM_EP)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_vec (fall_vec),
    .clr_vec  (clr_vec),
    .pend     (pend)
  );

  assign hs_code  = hs_code_i;
  assign irq_pend = pend;
  assign irq_any  = |pend;

  // Combinational register readback.
  always_comb begin
    cpu_rdata = '0;
    unique case (rsel)
      RG_STAT: begin
        for (int e = 1; e <= NUM_EP; e++)
          if (rep == EP_W'(e)) cpu_rdata = fmt_status(busy_vec[e], stall_vec[e]);
      end
      RG_BCNT: begin
        for (int e = 1; e <= NUM_EP; e++)
          if (rep == EP_W'(e)) cpu_rdata = DATA_W'(bcnt_arr[e]);
      end
      RG_PEND: begin
        if (rep == '0) cpu_rdata = DATA_W'({pend, 1'b0});
      end
      default: cpu_rdata = '0;
    endcase
  end

endmodule

// File: rtl/usb_in_arm_chk.sv
module usb_in_arm_chk
  import usb_in_arm_pkg::*;
#(
  parameter int NUM_EP = 7,
  parameter int EP_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NUM_EP:1] busy_vec,
  input logic [NUM_EP:1] stall_vec,
  input logic [NUM_EP:1] arm_evt,
  input logic [NUM_EP:1] pend,
  input logic            tok_valid,
  input logic [EP_W-1:0] tok_ep,
  input logic            hs_valid,
  input logic [1:0]      hs_code,
  input logic            xfer_done,
  input logic [EP_W-1:0] xfer_ep
);

  logic            tok_busy;
  logic            tok_stall;
  logic [NUM_EP:1] done_mask;

  always_comb begin
    tok_busy  = 1'b0;
    tok_stall = 1'b0;
    done_mask = '0;
    for (int e = 1; e <= NUM_EP; e++) begin
      if (tok_ep == EP_W'(e)) begin
        tok_busy  = busy_vec[e];
        tok_stall = stall_vec[e];
      end
      if (xfer_done && xfer_ep == EP_W'(e)) done_mask[e] = 1'b1;
    end
  end

  AST_ARM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|arm_evt) |=> ((busy_vec & $past(arm_evt)) == $past(arm_evt))); // R2

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done_mask & busy_vec)) |=> ((busy_vec & $past(done_mask)) == '0)); // R3

  AST_HS_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(tok_valid)); // R4

  AST_NAK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !$past(tok_busy) && !$past(tok_stall)) |-> (hs_code == HS_NAK)); // R4

  AST_STALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && $past(tok_stall)) |-> (hs_code == HS_STALL)); // R6

  AST_NO_DIRECT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((busy_vec & ~$past(busy_vec) & ~$past(arm_evt)) == '0)); // R7

  AST_FALL_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(busy_vec) & ~busy_vec)) |-> ((($past(busy_vec) & ~busy_vec) & ~pend) == '0)); // R9

endmodule

bind usb_in_arm_ctrl usb_in_arm_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_vec  (busy_vec),
  .stall_vec (stall_vec),
  .arm_evt   (arm_evt),
  .pend      (pend),
  .tok_valid (tok_valid),
  .tok_ep    (tok_ep),
  .hs_valid  (hs_valid),
  .hs_code   (hs_code),
  .xfer_done (xfer_done),
  .xfer_ep   (xfer_ep)
);

// File: tb/test_usb_in_arm_ctrl.sv
module test_usb_in_arm_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0;
  logic [4:0] cpu_waddr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [4:0] cpu_raddr = '0;
  logic [7:0] cpu_rdata;
  logic       tok_valid = 1'b0;
  logic [2:0] tok_ep = '0;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic [6:0] hs_len;
  logic       xfer_done = 1'b0;
  logic [2:0] xfer_ep = '0;
  logic [7:1] irq_pend;
  logic       irq_any;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  bit       m_busy  [1:7];
  bit       m_stall [1:7];
  bit [6:0] m_bcnt  [1:7];
  bit [7:1] m_pend;

  always #2.5 clk = ~clk;

  usb_in_arm_ctrl i_usb_in_arm_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
    .cpu_wdata(cpu_wdata), .cpu_raddr(cpu_raddr), .cpu_rdata(cpu_rdata),
    .tok_valid(tok_valid), .tok_ep(tok_ep), .hs_valid(hs_valid),
    .hs_code(hs_code), .hs_len(hs_len), .xfer_done(xfer_done),
    .xfer_ep(xfer_ep), .irq_pend(irq_pend), .irq_any(irq_any)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_read(input bit [4:0] a);
    bit [2:0] ep = a[2:0];
    case (a[4:3])
      2'd0:    return (ep != 0) ? {6'b0, m_busy[ep], m_stall[ep]} : 8'h00;
      2'd1:    return (ep != 0) ? {1'b0, m_bcnt[ep]} : 8'h00;
      2'd2:    return (ep == 0) ? {m_pend, 1'b0} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  // Expected handshake {valid, code, len} for a token in the current model state.
  function automatic bit [9:0] exp_hs(input bit tv, input bit [2:0] te);
    if (!tv || te == 0)  return 10'h000;
    if (m_stall[te])     return {1'b1, 2'b11, 7'd0};
    if (m_busy[te])      return {1'b1, 2'b01, m_bcnt[te]};
    return {1'b1, 2'b10, 7'd0};
  endfunction

  task automatic step(input bit we, input bit [4:0] wa, input bit [7:0] wd,
                      input bit tv, input bit [2:0] te,
                      input bit xd, input bit [2:0] xe,
                      input bit [4:0] ra, input string tag);
    bit [9:0] ehs;
    bit [7:1] fall;
    bit [7:1] clr;
    @(negedge clk);
    cpu_we = we; cpu_waddr = wa; cpu_wdata = wd;
    tok_valid = tv; tok_ep = te; xfer_done = xd; xfer_ep = xe;
    ehs  = exp_hs(tv, te);
    fall = '0;
    clr  = (we && wa[4:3] == 2'd2 && wa[2:0] == 0) ? wd[7:1] : 7'd0;
    for (int e = 1; e <= 7; e++) begin
      bit hit  = we && wa[2:0] == e;
      bit arm  = hit && wa[4:3] == 2'd1;
      bit stw  = hit && wa[4:3] == 2'd0;
      bit dn   = xd && xe == e;
      if (m_busy[e]) begin
        if ((stw && wd[1]) || dn) begin m_busy[e] = 0; fall[e] = 1; end
      end else if (arm) begin
        m_busy[e] = 1; m_bcnt[e] = wd[6:0];
      end
      if (stw) m_stall[e] = wd[0];
    end
    m_pend = (m_pend & ~clr) | fall;
    @(posedge clk); #1;
    check({hs_valid, hs_code, hs_len} == ehs,
          (ehs[8:7] == 2'b11) ? "R6 stall answer" :
          (ehs[8:7] == 2'b01) ? "R5 data answer" : "R4 nak/none answer",
          {hs_valid, hs_code, hs_len}, ehs);
    check(irq_pend == m_pend && irq_any == (|m_pend), "R9 R10 pending",
          {irq_any, irq_pend}, {|m_pend, m_pend});
    cpu_raddr = ra; #1;
    check(cpu_rdata == exp_read(ra), tag, cpu_rdata, exp_read(ra));
  endtask

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int e = 1; e <= 7; e++) begin m_busy[e] = 0; m_stall[e] = 0; m_bcnt[e] = 0; end
    m_pend = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 and R8: reset image of every address
    for (int a = 0; a < 32; a++) begin
      cpu_raddr = 5'(a); #1;
      check(cpu_rdata == exp_read(5'(a)), "R1 R8 reset readback", cpu_rdata, exp_read(5'(a)));
    end
    check(irq_pend == 0 && !irq_any && !hs_valid, "R1 reset outputs", {irq_any, irq_pend}, 0);

    // R2: arm ep3 with 10
    step(1, 5'h0B, 8'd10, 0, 0, 0, 0, 5'h03, "R2 status after arm");
    step(0, 0, 0, 0, 0, 0, 0, 5'h0B, "R2 byte count stored");
    // R11: second count write ignored
    step(1, 5'h0B, 8'd20, 0, 0, 0, 0, 5'h0B, "R11 count unchanged");
    step(0, 0, 0, 0, 0, 0, 0, 5'h03, "R11 busy kept");
    // R5 data, R4 ep0 and idle ep
    step(0, 0, 0, 1, 3, 0, 0, 5'h03, "R5 busy after token");
    step(0, 0, 0, 1, 0, 0, 0, 5'h03, "R4 ep0 token");
    step(0, 0, 0, 1, 4, 0, 0, 5'h04, "R4 idle status");
    step(0, 0, 0, 0, 0, 0, 0, 5'h03, "R4 settle");
    // R7: write 0 to busy has no effect; status write sets stall
    step(1, 5'h03, 8'h00, 0, 0, 0, 0, 5'h03, "R7 write0 keeps busy");
    step(1, 5'h04, 8'hFD, 0, 0, 0, 0, 5'h04, "R7 no direct set");
    step(0, 0, 0, 1, 4, 0, 0, 5'h04, "R6 stall idle");
    step(1, 5'h03, 8'h01, 0, 0, 0, 0, 5'h03, "R7 stall with busy");
    step(0, 0, 0, 1, 3, 0, 0, 5'h03, "R6 stall over data");
    step(1, 5'h03, 8'h00, 0, 0, 0, 0, 5'h03, "R7 unstall");
    step(1, 5'h04, 8'h00, 0, 0, 0, 0, 5'h04, "R7 unstall idle");
    // R3: done for idle ep ignored, then for busy ep
    step(0, 0, 0, 0, 0, 1, 5, 5'h05, "R3 idle done ignored");
    step(0, 0, 0, 0, 0, 1, 0, 5'h10, "R3 ep0 done ignored");
    step(0, 0, 0, 0, 0, 1, 3, 5'h03, "R3 busy cleared");
    step(0, 0, 0, 1, 3, 0, 0, 5'h10, "R9 pending after done");
    // R12: pair disarm
    step(1, 5'h09, 8'd5, 0, 0, 0, 0, 5'h01, "R12 arm ep1");
    step(1, 5'h0A, 8'd6, 0, 0, 0, 0, 5'h02, "R12 arm ep2");
    step(1, 5'h01, 8'h02, 0, 0, 0, 0, 5'h02, "R12 ep2 still busy");
    step(0, 0, 0, 0, 0, 0, 0, 5'h01, "R12 ep1 disarmed");
    step(1, 5'h02, 8'h02, 0, 0, 0, 0, 5'h02, "R12 ep2 disarmed");
    // R10: clear pending, then clear racing a new request
    step(1, 5'h10, 8'h0E, 0, 0, 0, 0, 5'h10, "R10 cleared");
    step(1, 5'h0E, 8'd9, 0, 0, 0, 0, 5'h06, "R10 arm ep6");
    step(1, 5'h10, 8'h40, 0, 0, 1, 6, 5'h10, "R10 new request wins");
    step(1, 5'h10, 8'h40, 0, 0, 0, 0, 5'h10, "R10 clear after");

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      bit [4:0] wa = 5'($urandom_range(0, 31));
      bit [7:0] wd = 8'($urandom);
      if (wa[4:3] == 2'd0 && $urandom_range(0, 3) != 0) wd[1] = 1'b0;
      if (wa[4:3] == 2'd0 && $urandom_range(0, 3) != 0) wd[0] = 1'b0;
      step($urandom_range(0, 1) == 1, wa, wd,
           $urandom_range(0, 2) != 0, 3'($urandom_range(0, 7)),
           $urandom_range(0, 3) == 0, 3'($urandom_range(0, 7)),
           5'($urandom_range(0, 31)), "R8 random readback");
    end
    step(0, 0, 0, 0, 0, 0, 0, 5'h10, "R8 final readback");

    done_flag = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule